// File: doc/BRIEF.md
# Pause-Pulse Reader Bit Modulator

This block turns a short reader-to-card frame into a length-coded waveform on one output line. The line rests high. Every bit opens with a low pause of fixed length. The line then goes high again, and the bit's value is carried by how long the whole bit lasts. Bits leave least significant first. Each bit is first combined with an external keystream bit by XOR. One further pause closes the frame.

A caller places the frame word and its bit count on the inputs and pulses `start_i` for one cycle. While the frame is on the line, `busy_o` stays high. `ks_adv_o` pulses once as each data bit finishes, which tells the external keystream source to step. `done_o` pulses once after the closing pause. All durations are parameters in microseconds. An internal divider derives a microsecond tick from the system clock, so every duration equals its microsecond value times `CLK_HZ / 1_000_000` clock cycles.

The keystream source must hold `ks_bit_i` steady between two advance pulses. The block reads `ks_bit_i` throughout a bit to decide how long that bit lasts.

Top module: `pp_reader_mod`

## Requirements
- R1: After synchronous reset, and whenever `busy_o` is low, `mod_o` is high and `busy_o`, `done_o` and `ks_adv_o` are low.
- R2: Every data bit and the closing mark begin with `mod_o` low for exactly `PAUSE_US` microseconds, starting in the first cycle after the bit begins; `mod_o` is then high for the rest of the bit.
- R3: A transmitted 1 lasts `T1_US` microseconds and a transmitted 0 lasts `T0_US` microseconds, both counted from the start of the bit's pause.
- R4: Frame bits go out in order, starting with bit 0 of `frame_i`, and the number sent equals the `len_i` value captured at start.
- R5: The transmitted value of each bit is the frame bit XOR `ks_bit_i`. `ks_adv_o` is high for exactly one cycle, the last cycle of each data bit, so a frame produces one pulse per data bit.
- R6: The last data bit is followed at once by one closing pause of `PAUSE_US`. `busy_o` is high from the cycle after the accepted start until that pause ends.
- R7: While `busy_o` is high, `start_i` is ignored, and the frame in progress is not disturbed.
- R8: `done_o` is high for exactly one cycle: the first cycle after the closing pause, when `busy_o` has already dropped. A `start_i` pulse in that same cycle is accepted.
- R9: A `len_i` of 0 sends only the closing pause and produces no `ks_adv_o` pulse.
- R10: A `len_i` above `FRAME_W` is treated as `FRAME_W`.
- R11: One microsecond equals `CLK_HZ / 1_000_000` clock cycles, so the time the frame holds `busy_o` high is the sum of the bit periods plus one pause, multiplied by that ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to send a frame |
| frame_i | input | FRAME_W | Frame data, bit 0 sent first |
| len_i | input | $clog2(FRAME_W+1) | Number of bits to send |
| ks_bit_i | input | 1 | Current keystream bit, held between advances |
| ks_adv_o | output | 1 | Step request to the keystream source, one per data bit |
| mod_o | output | 1 | Modulation line, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the closing pause |

## Verification
Two pairs of events can land in the same cycle. In the first pair, the completion pulse of one frame coincides with the start request of the next. The bench provokes this by raising `start_i` in the very cycle `done_o` is seen high. It then expects the second frame's first pause to begin in the next cycle and its full waveform to follow. In the second pair, the last data bit's advance pulse coincides with the switch into the closing pause. The bench's cycle model expects `ks_adv_o` high and `mod_o` still high in that cycle, then `mod_o` low in the next cycle, with no additional advance pulse. A start request issued in the middle of a long frame must leave the waveform and the advance count of that frame unchanged.

// File: rtl/pp_mod_pkg.sv
package pp_mod_pkg;

   typedef enum logic [1:0] {
      PP_IDLE = 2'd0,
      PP_DATA = 2'd1,
      PP_EOF  = 2'd2
   } pp_state_e;

endpackage

// File: rtl/pp_us_tick.sv
// Microsecond tick divider. Held at phase zero while not running so that
// every frame starts on a whole microsecond boundary.
module pp_us_tick #(
   parameter int unsigned DIV = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("pp_us_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick_o = run_i;
   end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst || !run_i) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick_o = run_i && (cnt_q == LAST);
   end

endmodule

// File: rtl/pp_bit_timer.sv
// Counts whole microseconds since the start of the current bit or pause.
module pp_bit_timer #(
   parameter int unsigned US_W = 7
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            run_i,
   input  logic            clear_i,
   input  logic            tick_i,
   output logic [US_W-1:0] us_o
);

   logic [US_W-1:0] us_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i || !run_i) begin
         us_q <= '0;
      end else if (tick_i) begin
         us_q <= us_q + 1'b1;
      end
   end

   assign us_o = us_q;

endmodule

// File: rtl/pp_frame_seq.sv
// Holds the frame, shifts it out bit 0 first and tracks bits remaining.
module pp_frame_seq #(
   parameter int unsigned FRAME_W = 32,
   parameter int unsigned LEN_W   = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic               step_i,
   output logic               bit_o,
   output logic               last_o,
   output logic               zero_len_o
);

   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(FRAME_W);

   logic [FRAME_W-1:0] shift_q;
   logic [LEN_W-1:0]   left_q;
   logic [LEN_W-1:0]   len_eff;

   always_comb begin
      if (len_i > MAX_LEN) begin
         len_eff = MAX_LEN;
      end else begin
         len_eff = len_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q <= '0;
         left_q  <= '0;
      end else if (load_i) begin
         shift_q <= frame_i;
         left_q  <= len_eff;
      end else if (step_i) begin
         shift_q <= shift_q >> 1;
         left_q  <= left_q - 1'b1;
      end
   end

   assign bit_o      = shift_q[0];
   assign last_o     = (left_q == LEN_W'(1));
   assign zero_len_o = (len_i == '0);

endmodule

// File: rtl/pp_reader_mod.sv
module pp_reader_mod #(
   parameter int unsigned CLK_HZ   = 100_000_000,
   parameter int unsigned PAUSE_US = 20,
   parameter int unsigned T0_US    = 60,
   parameter int unsigned T1_US    = 100,
   parameter int unsigned FRAME_W  = 32,
   localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic               ks_bit_i,
   output logic               ks_adv_o,
   output logic               mod_o,
   output logic               busy_o,
   output logic               done_o
);

   import pp_mod_pkg::*;

   localparam int unsigned DIV  = CLK_HZ / 1_000_000;
   localparam int unsigned US_W = $clog2(T1_US + 1);
   localparam logic [US_W-1:0] PAUSE_LAST = US_W'(PAUSE_US - 1);
   localparam logic [US_W-1:0] PAUSE_LEN  = US_W'(PAUSE_US);
   localparam logic [US_W-1:0] T0_LAST    = US_W'(T0_US - 1);
   localparam logic [US_W-1:0] T1_LAST    = US_W'(T1_US - 1);

   if (CLK_HZ % 1_000_000 != 0 || DIV < 1) begin : g_bad_clk
      $error("pp_reader_mod: CLK_HZ must be a whole number of MHz");
   end
   if (PAUSE_US < 1 || PAUSE_US >= T0_US || T0_US >= T1_US) begin : g_bad_times
      $error("pp_reader_mod: need 1 <= PAUSE_US < T0_US < T1_US");
   end
   if (FRAME_W < 1) begin : g_bad_width
      $error("pp_reader_mod: FRAME_W must be at least 1");
   end

   pp_state_e       st_q, st_d;
   logic            running;
   logic            tick;
   logic [US_W-1:0] us_cnt;
   logic            cur_bit, last_bit, zero_len;
   logic            tx_bit;
   logic [US_W-1:0] period_last;
   logic            accept, bit_end, eof_end, timer_clear;
   logic            done_q;

   assign running = (st_q != PP_IDLE);
   assign accept  = start_i && (st_q == PP_IDLE);

   pp_us_tick #(.DIV(DIV)) tick_i (
      .clk    (clk),
      .rst    (rst),
      .run_i  (running),
      .tick_o (tick)
   );

   pp_bit_timer #(.US_W(US_W)) timer_i (
      .clk     (clk),
      .rst     (rst),
      .run_i   (running),
      .clear_i (timer_clear),
      .tick_i  (tick),
      .us_o    (us_cnt)
   );

   pp_frame_seq #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) seq_i (
      .clk        (clk),
      .rst        (rst),
      .load_i     (accept),
      .frame_i    (frame_i),
      .len_i      (len_i),
      .step_i     (bit_end),
      .bit_o      (cur_bit),
      .last_o     (last_bit),
      .zero_len_o (zero_len)
   );

   // Whitened bit; the keystream is stable until ks_adv_o fires.
   assign tx_bit      = cur_bit ^ ks_bit_i;
   assign period_last = tx_bit ? T1_LAST : T0_LAST;

   assign bit_end     = (st_q == PP_DATA) && tick && (us_cnt == period_last);
   assign eof_end     = (st_q == PP_EOF) && tick && (us_cnt == PAUSE_LAST);
   assign timer_clear = bit_end || eof_end;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PP_IDLE: begin
            if (accept) begin
               st_d = zero_len ? PP_EOF : PP_DATA;
            end
         end
         PP_DATA: begin
            if (bit_end && last_bit) begin
               st_d = PP_EOF;
            end
         end
         PP_EOF: begin
            if (eof_end) begin
               st_d = PP_IDLE;
            end
         end
         default: st_d = PP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= PP_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= eof_end;
      end
   end

   assign mod_o    = !(running && (us_cnt < PAUSE_LEN));
   assign busy_o   = running;
   assign done_o   = done_q;
   assign ks_adv_o = bit_end;

endmodule

// File: rtl/pp_reader_mod_chk.sv
module pp_reader_mod_chk (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic ks_adv_o,
   input logic mod_o,
   input logic busy_o,
   input logic done_o
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (mod_o && !ks_adv_o));

   a_r2_frame_opens_low: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> !mod_o);

   a_r5_adv_single: assert property (@(posedge clk) disable iff (rst)
      ks_adv_o |=> !ks_adv_o);

   a_r5_adv_line_high: assert property (@(posedge clk) disable iff (rst)
      ks_adv_o |-> (busy_o && mod_o));

   a_r6_pause_follows_bit: assert property (@(posedge clk) disable iff (rst)
      ks_adv_o |=> (busy_o && !mod_o));

   a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> $past(start_i));

   a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind pp_reader_mod pp_reader_mod_chk chk_i (
   .clk      (clk),
   .rst      (rst),
   .start_i  (start_i),
   .ks_adv_o (ks_adv_o),
   .mod_o    (mod_o),
   .busy_o   (busy_o),
   .done_o   (done_o)
);

// File: tb/pp_reader_mod_tb_top.sv
module pp_reader_mod_tb_top;

   // 4 "MHz" scaling keeps frames short: one microsecond = 4 clocks.
   localparam int unsigned CLK_HZ   = 4_000_000;
   localparam int unsigned D        = CLK_HZ / 1_000_000;
   localparam int unsigned PAUSE_US = 20;
   localparam int unsigned T0_US    = 60;
   localparam int unsigned T1_US    = 100;
   localparam int unsigned FRAME_W  = 32;
   localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               start_i = 1'b0;
   logic [FRAME_W-1:0] frame_i = '0;
   logic [LEN_W-1:0]   len_i = '0;
   logic               ks_bit_i;
   logic               ks_adv_o, mod_o, busy_o, done_o;

   always #5 clk = ~clk;

   pp_reader_mod #(
      .CLK_HZ(CLK_HZ), .PAUSE_US(PAUSE_US), .T0_US(T0_US),
      .T1_US(T1_US), .FRAME_W(FRAME_W)
   ) dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .frame_i(frame_i),
      .len_i(len_i), .ks_bit_i(ks_bit_i), .ks_adv_o(ks_adv_o),
      .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o)
   );

   // Keystream source: 16-bit LFSR stepped on each advance request.
   function automatic logic [15:0] ks_step(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   logic [15:0] ks_q = 16'hACE1;
   assign ks_bit_i = ks_q[0];
   always @(posedge clk) if (ks_adv_o) ks_q <= ks_step(ks_q);

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // Expected {mod, busy, done, adv} for each coming cycle.
   logic [3:0] q[$];
   bit  prev_busy = 1'b0;
   int  adv_seen, low_seen, busy_seen;
   int  exp_adv, exp_low, exp_busy;

   task automatic build(input logic [31:0] f, input int len, input logic [15:0] ks0);
      logic [15:0] ks = ks0;
      int n = (len > FRAME_W) ? FRAME_W : len;
      q.delete();
      exp_busy = 0;
      for (int i = 0; i < n; i++) begin
         bit b = f[i] ^ ks[0];
         int per = (b ? T1_US : T0_US) * D;
         for (int c = 0; c < per; c++) begin
            q.push_back({(c < PAUSE_US * D) ? 1'b0 : 1'b1, 1'b1, 1'b0, (c == per - 1) ? 1'b1 : 1'b0});
         end
         exp_busy += per;
         ks = ks_step(ks);
      end
      for (int c = 0; c < PAUSE_US * D; c++) q.push_back(4'b0100);
      exp_busy += PAUSE_US * D;
      q.push_back(4'b1010);
      exp_adv = n;
      exp_low = (n + 1) * PAUSE_US * D;
   endtask

   // Model acceptance at the active edge.
   always @(posedge clk) begin
      if (rst) begin
         q.delete();
      end else if (start_i && !prev_busy) begin
         build(frame_i, int'(len_i), ks_q);
         adv_seen  = 0;
         low_seen  = 0;
         busy_seen = 0;
      end
   end

   // Cycle-by-cycle comparison away from the edge.
   always @(negedge clk) begin
      if (rst) begin
         prev_busy = 1'b0;
      end else begin
         logic [3:0] exp_v;
         logic [3:0] act_v;
         exp_v = (q.size() > 0) ? q.pop_front() : 4'b1000;
         act_v = {mod_o, busy_o, done_o, ks_adv_o};
         prev_busy = exp_v[2];
         checks++;
         if (act_v !== exp_v) begin
            fails++;
            if (act_v[3] !== exp_v[3])
               $display("FAIL R3 cycle %0d mod_o: actual %b expected %b", cyc, act_v[3], exp_v[3]);
            else if (act_v[2] !== exp_v[2])
               $display("FAIL R6 cycle %0d busy_o: actual %b expected %b", cyc, act_v[2], exp_v[2]);
            else if (act_v[1] !== exp_v[1])
               $display("FAIL R8 cycle %0d done_o: actual %b expected %b", cyc, act_v[1], exp_v[1]);
            else
               $display("FAIL R5 cycle %0d ks_adv_o: actual %b expected %b", cyc, act_v[0], exp_v[0]);
         end
         if (ks_adv_o) adv_seen++;
         if (busy_o && !mod_o) low_seen++;
         if (busy_o) busy_seen++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic send(input logic [31:0] f, input int l, input bit b2b);
      if (!b2b) @(negedge clk);
      frame_i = f;
      len_i   = LEN_W'(l);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done_o);
   endtask

   task automatic frame_totals(input string tag);
      check(adv_seen == exp_adv, {tag, " R4 bit count"}, adv_seen, exp_adv);
      check(low_seen == exp_low, "R2 pause time", low_seen, exp_low);
      check(busy_seen == exp_busy, "R11 frame duration", busy_seen, exp_busy);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs during and after reset
      check({mod_o, busy_o, done_o, ks_adv_o} == 4'b1000, "R1 in reset", int'({mod_o, busy_o, done_o, ks_adv_o}), 8);
      rst = 1'b0;
      @(negedge clk);
      check({mod_o, busy_o, done_o, ks_adv_o} == 4'b1000, "R1 after reset", int'({mod_o, busy_o, done_o, ks_adv_o}), 8);

      // single bit
      send(32'h1, 1, 1'b0);
      wait_done();
      frame_totals("single");
      @(negedge clk);
      check(done_o == 1'b0, "R8 done width", done_o, 0);

      // R9: empty frame
      send(32'hFFFF_FFFF, 0, 1'b0);
      wait_done();
      check(adv_seen == 0, "R9 no advance", adv_seen, 0);
      check(low_seen == PAUSE_US * D, "R9 closing pause only", low_seen, PAUSE_US * D);

      // mixed pattern, R3 and R5 via cycle model
      send(32'h0000_0016, 5, 1'b0);
      wait_done();
      frame_totals("R5 mixed");

      // full width, with an ignored start in the middle (R7)
      send(32'hC3A5_0F96, 32, 1'b0);
      repeat (700) @(negedge clk);
      frame_i = 32'h0;
      len_i   = LEN_W'(3);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      check(adv_seen == 32, "R7 frame undisturbed", adv_seen, 32);
      frame_totals("full");

      // R10: length above width clamps
      send(32'h1234_5678, 40, 1'b0);
      wait_done();
      check(adv_seen == FRAME_W, "R10 clamp", adv_seen, FRAME_W);

      // R8: start in the done cycle is accepted
      send(32'h3, 3, 1'b0);
      wait_done();
      send(32'hA5, 8, 1'b1);
      check(busy_o == 1'b1, "R8 back-to-back accepted", busy_o, 1);
      wait_done();
      frame_totals("R8 second");

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule